// File: doc/BRIEF.md
# Sectored External SRAM Wait-State Controller

This block connects a simple single-beat internal request port to an asynchronous external SRAM. It takes one request at a time. It drives the address and write data onto the external bus, together with active-low read and write strobes and an output enable for the data pins. When the access is done it returns a one-cycle ready pulse and the read data.

The external window begins at 0x2200 and runs to the top of the 16-bit space. A 3-bit split code divides this window into a lower sector and an upper sector, and each sector has its own 2-bit wait-state code. The wait-state code sets how long the strobe stays low. Its largest value also keeps the bus idle for one extra cycle before the next address may appear. The split code and both wait-state codes are sampled once, when a request is accepted, and they stay fixed for the rest of that access.

Every external access has the same shape. First comes one setup cycle, in which the address is driven and the strobes are high. Next comes the strobe-low phase. Then ready rises in the cycle after the strobe goes back high.

Top module: `sram_ws_ctrl`

## Requirements
- R1: A request whose address is below 0x2200 produces no strobe. It is answered with rsp_ready high in the cycle after acceptance, with rsp_rdata equal to 0. Addresses from 0x2200 to 0xFFFF are forwarded to the external bus.
- R2: With a split code of 0 or 1, the upper-sector wait code (cfg_ws_upper) governs every external address. With a split code L from 2 to 7, addresses at or above L×0x2000 use cfg_ws_upper, and addresses below that use cfg_ws_lower.
- R3: An external access drives ext_addr for one setup cycle with both strobes high. The strobe then stays low for 1, 2, 3 or 3 cycles for wait codes 00, 01, 10 and 11 respectively. Reads use ext_rd_n and writes use ext_wr_n.
- R4: After an access that used wait code 11, a request presented in the cycle rsp_ready is high is ignored, and ext_addr keeps its old value. With codes 00 to 10, such a request is accepted.
- R5: ext_rd_n and ext_wr_n are never low at the same time, and ext_addr does not change while either strobe is low.
- R6: For an external access, rsp_ready is high for exactly one cycle: the cycle after the strobe returns high. For a read, rsp_rdata holds the ext_rdata value present in the last strobe-low cycle.
- R7: For a write, ext_data_oe is high and ext_wdata holds the write data from the setup cycle through the cycle after the strobe rises. ext_data_oe then falls. It is low throughout a read.
- R8: A request presented while an access is in progress is ignored. It produces no further strobe and no extra ready pulse.
- R9: The split code and the wait codes are sampled at acceptance. Changing them during an access does not alter that access's strobe length.
- R10: After reset, both strobes are high, and ext_data_oe, rsp_ready, rsp_rdata and ext_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_addr | input | 16 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data returned |
| cfg_split | input | 3 | Sector split code |
| cfg_ws_lower | input | 2 | Lower-sector wait code |
| cfg_ws_upper | input | 2 | Upper-sector wait code |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_data_oe | output | 1 | Data pin output enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rdata | input | 8 | External read data |

## Verification
The assertions assume that req_valid arrives as a single-cycle pulse and that the external memory returns data combinationally while the read strobe is low. They do not assume that requests respect the busy window, because R4 and R8 require the block itself to drop early pulses. The stimulus drives every request for exactly one cycle, at the falling clock edge. Its memory model presents a marker value whenever the read strobe is high. It sends early requests on purpose, only in the scenarios that exercise the ignore rules.

// File: rtl/sram_ws_pkg.sv
package sram_ws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD
  } acc_state_t;

  typedef struct packed {
    logic [1:0] extra;  // strobe cycles beyond the first
    logic       hold;   // one idle cycle after completion
  } ws_timing_t;

  function automatic ws_timing_t ws_decode(input logic [1:0] code);
    ws_timing_t t;
    case (code)
      2'b00:   begin t.extra = 2'd0; t.hold = 1'b0; end
      2'b01:   begin t.extra = 2'd1; t.hold = 1'b0; end
      2'b10:   begin t.extra = 2'd2; t.hold = 1'b0; end
      default: begin t.extra = 2'd2; t.hold = 1'b1; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sram_sector_decode.sv
module sram_sector_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SPLIT_W  = 3,
  parameter int unsigned EXT_BASE = 'h2200
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SPLIT_W-1:0] split,
  output logic               is_ext,
  output logic               is_upper
);
  localparam logic [ADDR_W-1:0]  BASE_A     = EXT_BASE[ADDR_W-1:0];
  localparam logic [SPLIT_W-1:0] MIN_SPLIT  = SPLIT_W'(2);

  logic [SPLIT_W-1:0] seg;

  assign seg      = addr[ADDR_W-1 -: SPLIT_W];
  assign is_ext   = (addr >= BASE_A);
  // codes below MIN_SPLIT leave a single (upper) sector
  assign is_upper = (split < MIN_SPLIT) ? 1'b1 : (seg >= split);
endmodule

// File: rtl/sram_ws_select.sv
module sram_ws_select
  import sram_ws_pkg::*;
(
  input  logic       is_upper,
  input  logic [1:0] ws_lower,
  input  logic [1:0] ws_upper,
  output ws_timing_t timing
);
  logic [1:0] code;

  assign code   = is_upper ? ws_upper : ws_lower;
  assign timing = ws_decode(code);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_ws_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              is_ext,
  input  ws_timing_t        timing,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_data_oe,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  acc_state_t state;
  logic [1:0] cnt;
  logic       hold_q;
  logic       we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      hold_q      <= 1'b0;
      we_q        <= 1'b0;
      rsp_ready   <= 1'b0;
      rsp_rdata   <= '0;
      ext_addr    <= '0;
      ext_wdata   <= '0;
      ext_data_oe <= 1'b0;
      ext_rd_n    <= 1'b1;
      ext_wr_n    <= 1'b1;
    end else begin
      rsp_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          ext_data_oe <= 1'b0;
          if (req_valid) begin
            if (!is_ext) begin
              rsp_ready <= 1'b1;
              rsp_rdata <= '0;
            end else begin
              ext_addr    <= req_addr;
              ext_wdata   <= req_wdata;
              ext_data_oe <= req_we;
              we_q        <= req_we;
              cnt         <= timing.extra;
              hold_q      <= timing.hold;
              state       <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (we_q) ext_wr_n <= 1'b0;
          else      ext_rd_n <= 1'b0;
          state <= ST_STRB;
        end
        ST_STRB: begin
          if (cnt == 2'd0) begin
            ext_rd_n  <= 1'b1;
            ext_wr_n  <= 1'b1;
            rsp_ready <= 1'b1;
            if (!we_q) rsp_rdata <= ext_rdata;
            state <= hold_q ? ST_HOLD : ST_IDLE;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: begin
          ext_data_oe <= 1'b0;
          state       <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_ws_ctrl.sv
module sram_ws_ctrl
  import sram_ws_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SPLIT_W  = 3,
  parameter int unsigned EXT_BASE = 'h2200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_we,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [SPLIT_W-1:0] cfg_split,
  input  logic [1:0]         cfg_ws_lower,
  input  logic [1:0]         cfg_ws_upper,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic [DATA_W-1:0]  ext_wdata,
  output logic               ext_data_oe,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  input  logic [DATA_W-1:0]  ext_rdata
);
  logic       is_ext;
  logic       is_upper;
  ws_timing_t timing;

  sram_sector_decode #(
    .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W), .EXT_BASE(EXT_BASE)
  ) u_dec (
    .addr(req_addr), .split(cfg_split), .is_ext(is_ext), .is_upper(is_upper)
  );

  sram_ws_select u_sel (
    .is_upper(is_upper), .ws_lower(cfg_ws_lower), .ws_upper(cfg_ws_upper),
    .timing(timing)
  );

  sram_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .is_ext(is_ext), .timing(timing),
    .ext_rdata(ext_rdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_data_oe(ext_data_oe),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );
endmodule

// File: rtl/sram_ws_ctrl_chk.sv
module sram_ws_ctrl_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_data_oe,
  input logic              ext_rd_n,
  input logic              ext_wr_n
);
  logic [2:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (!ext_rd_n || !ext_wr_n) low_run <= (low_run == 3'd7) ? low_run : low_run + 3'd1;
    else low_run <= '0;
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> $stable(ext_addr));

  a_r3_strobe_max: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> (low_run < 3'd3));

  a_r7_oe_write: assert property (@(posedge clk) disable iff (rst)
    !ext_wr_n |-> ext_data_oe);

  a_r7_no_oe_read: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_data_oe);

  a_r6_ready_strobe_high: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> (ext_rd_n && ext_wr_n));
endmodule

bind sram_ws_ctrl sram_ws_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rsp_ready(rsp_ready), .ext_addr(ext_addr),
  .ext_data_oe(ext_data_oe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/sim_sram_ws_ctrl.sv
module sim_sram_ws_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_ready;
  logic [7:0]  rsp_rdata;
  logic [2:0]  cfg_split = '0;
  logic [1:0]  cfg_ws_lower = '0;
  logic [1:0]  cfg_ws_upper = '0;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_data_oe;
  logic        ext_rd_n;
  logic        ext_wr_n;
  logic [7:0]  ext_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: valid data only while the read strobe is low
  assign ext_rdata = !ext_rd_n ? mem_val(ext_addr) : 8'hEE;

  sram_ws_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .cfg_split(cfg_split), .cfg_ws_lower(cfg_ws_lower),
    .cfg_ws_upper(cfg_ws_upper), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_data_oe(ext_data_oe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_rdata(ext_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // single access; exp_n = strobe-low cycles expected (0 = internal, not forwarded)
  task automatic run_access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                            input int exp_n, input string req, input bit cfg_bump);
    int low = 0; int rk = 0; logic [7:0] rd = '0; bit bad_addr = 0; bit bad_oe = 0;
    bit wrong_strobe = 0; int exp_rk;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (cfg_bump) begin cfg_ws_upper = 2'b10; cfg_ws_lower = 2'b10; cfg_split = 3'd0; end
    for (int k = 1; k <= 8; k++) begin
      if (!ext_rd_n || !ext_wr_n) begin
        low++;
        if (ext_addr != a) bad_addr = 1;
        if (we && (!ext_data_oe || ext_wdata != wd)) bad_oe = 1;
        if (!we && ext_data_oe) bad_oe = 1;
        if ((we && !ext_rd_n) || (!we && !ext_wr_n)) wrong_strobe = 1;
      end
      if (exp_n > 0 && k == 1 && (!ext_rd_n || !ext_wr_n || ext_addr != a)) bad_addr = 1;
      if (we && exp_n > 0 && k == 1 && !ext_data_oe) bad_oe = 1;
      if (we && exp_n > 0 && k == exp_n + 2 && (!ext_data_oe || ext_wdata != wd)) bad_oe = 1;
      if (we && exp_n > 0 && k == exp_n + 3 && ext_data_oe) bad_oe = 1;
      if (rsp_ready) begin
        if (rk == 0) begin rk = k; rd = rsp_rdata; end
        else rk = 99;
      end
      if (k < 8) @(negedge clk);
    end
    exp_rk = (exp_n == 0) ? 1 : exp_n + 2;
    chk(low == exp_n, {req, " strobe cycles"}, low, exp_n);
    chk(rk == exp_rk, {req, " R6 ready cycle"}, rk, exp_rk);
    chk(!bad_addr && !wrong_strobe, {req, " R5 address/strobe"}, int'(bad_addr), 0);
    if (exp_n == 0) chk(rd == 8'h00, {req, " R1 rdata"}, rd, 0);
    else if (!we) chk(rd == mem_val(a), {req, " R6 rdata"}, rd, mem_val(a));
    else chk(!bad_oe, {req, " R7 write oe/data"}, int'(bad_oe), 0);
  endtask

  // R4: request offered in the ready cycle after an access with the given upper code
  task automatic hold_test(input logic [1:0] code);
    int low = 0; bit addr_moved = 0; int guard = 0;
    cfg_split = 3'd0; cfg_ws_upper = code;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h3000; req_we = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_ready && guard < 10) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_addr = 16'h5000;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (!ext_rd_n) low++;
      if (ext_addr != 16'h3000) addr_moved = 1;
      @(negedge clk);
    end
    if (code == 2'b11) begin
      chk(low == 0, "R4 code 11 ignores request in ready cycle", low, 0);
      chk(!addr_moved, "R4 address held", int'(addr_moved), 0);
    end else begin
      chk(low == 3, "R4 request accepted in ready cycle", low, 3);
    end
    idle_cycles(3);
  endtask

  // R8: request during an access
  task automatic busy_test();
    int low = 0; int rdy = 0;
    cfg_split = 3'd0; cfg_ws_upper = 2'b10;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h8123; req_we = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (!ext_rd_n) low++;
      if (rsp_ready) rdy++;
      @(negedge clk);
      req_valid = (k == 1);
      req_addr  = 16'h9000;
    end
    req_valid = 1'b0;
    chk(low == 3, "R8 busy request no extra strobe", low, 3);
    chk(rdy == 1, "R8 busy request no extra ready", rdy, 1);
    idle_cycles(3);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all R) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_cycles(3);
    @(negedge clk) rst = 1'b0;
    // R10 reset state
    chk(ext_rd_n && ext_wr_n, "R10 strobes high", {ext_rd_n, ext_wr_n}, 3);
    chk(!ext_data_oe && !rsp_ready, "R10 oe/ready low", {ext_data_oe, rsp_ready}, 0);
    chk(rsp_rdata == 0 && ext_addr == 0, "R10 rdata/addr zero", ext_addr, 0);

    // R3 strobe length per code, single sector
    cfg_split = 3'd0;
    cfg_ws_upper = 2'b00; run_access(16'h2200, 1'b0, 8'h00, 1, "R3 code00", 0);
    cfg_ws_upper = 2'b01; run_access(16'hFFFF, 1'b0, 8'h00, 2, "R3 code01", 0);
    cfg_ws_upper = 2'b10; run_access(16'h7A31, 1'b0, 8'h00, 3, "R3 code10", 0);
    cfg_ws_upper = 2'b11; run_access(16'h4C02, 1'b0, 8'h00, 3, "R3 code11", 0);
    idle_cycles(2);
    // R7 writes
    cfg_ws_upper = 2'b01; run_access(16'h3456, 1'b1, 8'hA5, 2, "R7 write code01", 0);
    cfg_ws_upper = 2'b00; run_access(16'hC001, 1'b1, 8'h3C, 1, "R7 write code00", 0);
    // R1 internal vs first external address
    cfg_ws_upper = 2'b01;
    run_access(16'h21FF, 1'b0, 8'h00, 0, "R1 internal 21FF", 0);
    run_access(16'h0000, 1'b1, 8'h11, 0, "R1 internal 0000", 0);
    // R2 sector split
    cfg_ws_lower = 2'b01; cfg_ws_upper = 2'b10;
    cfg_split = 3'd1; run_access(16'h2200, 1'b0, 8'h00, 3, "R2 split1 upper", 0);
    cfg_split = 3'd2; run_access(16'h3FFF, 1'b0, 8'h00, 2, "R2 split2 lower", 0);
    cfg_split = 3'd2; run_access(16'h4000, 1'b0, 8'h00, 3, "R2 split2 upper", 0);
    cfg_split = 3'd7; run_access(16'hDFFF, 1'b0, 8'h00, 2, "R2 split7 lower", 0);
    cfg_split = 3'd7; run_access(16'hE000, 1'b0, 8'h00, 3, "R2 split7 upper", 0);
    cfg_split = 3'd5; run_access(16'h9FFF, 1'b1, 8'h77, 2, "R2 split5 lower write", 0);
    // R9 configuration latched at acceptance
    cfg_split = 3'd0; cfg_ws_upper = 2'b00; cfg_ws_lower = 2'b00;
    run_access(16'h6000, 1'b0, 8'h00, 1, "R9 cfg change mid-access", 1);
    // R4 hold behaviour
    hold_test(2'b11);
    hold_test(2'b10);
    // R8 busy
    busy_test();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule